// File: doc/BRIEF.md
# DMA Descriptor Configuration Checker

This block looks over one DMA channel's transfer descriptor and the channel priority table, and flags configuration errors at the point in the channel's life where each error becomes meaningful. The descriptor, the priority table and the arbitration mode are held steady by the surrounding engine. The checker only evaluates them during a cycle in which the engine pulses one of its three lifecycle strobes: channel activation, minor-loop completion or major-loop completion.

Different classes of error are tied to different strobes. Alignment, byte-count, size-code and priority faults are reported at activation. A misaligned scatter-gather descriptor address is reported only at major-loop completion. A link-enable mismatch is reported only at minor-loop completion. Reported errors gather in a sticky flag vector. With each report the block also records the channel number that came with the strobe, sets a valid bit and, if enabled, raises an interrupt request. A one-cycle clear strobe empties the record.

Top module: `dma_cfg_checker`

## Requirements
- R1: A transfer size code s (legal values 0..5) means 2^s bytes. At activation, if the source size code is legal and either the source address or the source offset is not a multiple of 2^s, flag bit 0 sets.
- R2: At activation, if the destination size code is legal and either the destination address or the destination offset is not a multiple of 2^s, flag bit 1 sets.
- R3: At activation, if the minor-loop byte count is not a multiple of 2^s for a legal source size code, or for a legal destination size code, flag bit 2 sets.
- R4: At activation, if either size code is 6 or 7, flag bit 3 sets.
- R5: At activation, with fixed arbitration selected (fixed_arb_i=1), if any two channels in the 4-bit-per-channel priority table hold equal values, flag bit 4 sets. In round-robin mode (fixed_arb_i=0) equal priorities raise nothing.
- R6: Flag bit 5 sets only at major-loop completion, and only when scatter-gather is enabled and the next-descriptor address is not a multiple of 32. At any other strobe a misaligned address raises nothing.
- R7: Flag bit 6 sets only at minor-loop completion, and only when linking is enabled and the current-iteration link bit differs from the beginning-iteration link bit.
- R8: A faulty descriptor raises no flag in a cycle without a strobe.
- R9: Flags stay set until clear_i is pulsed. A clear with no error in the same cycle empties all flags and the valid bit. An error reported in the same cycle as a clear remains set after it.
- R10: In the cycle after a strobe that finds an error, err_vld_o is 1 and err_ch_o holds the channel number sampled with the strobe.
- R11: err_irq_o is 1 exactly when err_vld_o is 1 and err_irq_en_i is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| act_i | input | 1 | Channel activation strobe |
| minor_done_i | input | 1 | Minor-loop completion strobe |
| major_done_i | input | 1 | Major-loop completion strobe |
| clear_i | input | 1 | One-cycle clear of the error record |
| ch_i | input | CH_W | Channel number associated with the strobe |
| src_addr_i | input | ADDR_W | Source address |
| dst_addr_i | input | ADDR_W | Destination address |
| src_off_i | input | OFF_W | Signed source offset |
| dst_off_i | input | OFF_W | Signed destination offset |
| src_size_i | input | 3 | Source size code (log2 bytes) |
| dst_size_i | input | 3 | Destination size code (log2 bytes) |
| nbytes_i | input | CNT_W | Minor-loop byte count |
| sg_en_i | input | 1 | Scatter-gather enable |
| sg_addr_i | input | ADDR_W | Next-descriptor address |
| link_en_i | input | 1 | Minor-loop link enable |
| cur_link_i | input | 1 | Current-iteration link-enable bit |
| beg_link_i | input | 1 | Beginning-iteration link-enable bit |
| prio_i | input | NUM_CH*PRIO_W | Packed channel priority table |
| fixed_arb_i | input | 1 | 1 selects fixed-priority arbitration |
| err_irq_en_i | input | 1 | Error interrupt enable |
| err_flags_o | output | 7 | Sticky error flags, one bit per class |
| err_ch_o | output | CH_W | Channel of the most recent report |
| err_vld_o | output | 1 | An error is recorded |
| err_irq_o | output | 1 | Error interrupt request |

## Verification
A wrong gating term in the event logic shows up as a flag that appears one cycle after the wrong strobe, or that never appears after the right one. That is why every stimulus places a fault in front of both the matching strobe and a strobe that must not report it. A sticky register that loses or corrupts state shows up on the very next sampled cycle as a dropped bit, a stale channel number or an interrupt out of step with the valid bit. The bench therefore compares the whole record after every event, not only the newly raised bit.

// File: rtl/dma_cfg_pkg.sv
package dma_cfg_pkg;
  localparam int ERR_N       = 7;
  localparam int E_SRC_ALIGN = 0;
  localparam int E_DST_ALIGN = 1;
  localparam int E_COUNT     = 2;
  localparam int E_SIZE_CODE = 3;
  localparam int E_PRIO      = 4;
  localparam int E_SG_ALIGN  = 5;
  localparam int E_LINK      = 6;
  localparam int LOW_W       = 5;

  // Low-bit mask for a size code; illegal codes yield an empty mask.
  function automatic logic [LOW_W-1:0] size_mask(input logic [2:0] code);
    logic [LOW_W-1:0] m;
    case (code)
      3'd0:    m = 5'h00;
      3'd1:    m = 5'h01;
      3'd2:    m = 5'h03;
      3'd3:    m = 5'h07;
      3'd4:    m = 5'h0f;
      3'd5:    m = 5'h1f;
      default: m = 5'h00;
    endcase
    return m;
  endfunction

  function automatic logic size_legal(input logic [2:0] code);
    return code <= 3'd5;
  endfunction
endpackage

// File: rtl/dma_cfg_align.sv
module dma_cfg_align
  import dma_cfg_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 16,
  parameter int CNT_W  = 32
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [2:0]        size_i,
  output logic              addr_bad_o,
  output logic              cnt_bad_o,
  output logic              code_bad_o
);
  logic [LOW_W-1:0]  mask;
  logic [ADDR_W-1:0] mask_a;
  logic [OFF_W-1:0]  mask_o;
  logic [CNT_W-1:0]  mask_c;

  always_comb begin
    mask   = size_mask(size_i);
    mask_a = {{(ADDR_W-LOW_W){1'b0}}, mask};
    mask_o = {{(OFF_W-LOW_W){1'b0}}, mask};
    mask_c = {{(CNT_W-LOW_W){1'b0}}, mask};
    addr_bad_o = ((addr_i & mask_a) != '0) || ((off_i & mask_o) != '0);
    cnt_bad_o  = (cnt_i & mask_c) != '0;
    code_bad_o = !size_legal(size_i);
  end
endmodule

// File: rtl/dma_cfg_prio_uniq.sv
module dma_cfg_prio_uniq #(
  parameter int NUM_CH = 8,
  parameter int PRIO_W = 4
) (
  input  logic [NUM_CH*PRIO_W-1:0] prio_i,
  output logic                     dup_o
);
  localparam int PAIRS = NUM_CH * NUM_CH;
  logic [PAIRS-1:0] eq;

  genvar gi, gj;
  generate
    for (gi = 0; gi < NUM_CH; gi++) begin : g_row
      for (gj = 0; gj < NUM_CH; gj++) begin : g_col
        if (gj > gi) begin : g_cmp
          assign eq[gi*NUM_CH+gj] =
            prio_i[gi*PRIO_W +: PRIO_W] == prio_i[gj*PRIO_W +: PRIO_W];
        end else begin : g_none
          assign eq[gi*NUM_CH+gj] = 1'b0;
        end
      end
    end
  endgenerate

  assign dup_o = |eq;
endmodule

// File: rtl/dma_cfg_err_reg.sv
module dma_cfg_err_reg
  import dma_cfg_pkg::*;
#(
  parameter int CH_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ERR_N-1:0] new_err_i,
  input  logic [CH_W-1:0]  ch_i,
  input  logic             clear_i,
  output logic [ERR_N-1:0] flags_o,
  output logic             vld_o,
  output logic [CH_W-1:0]  ch_o
);
  logic [ERR_N-1:0] flags_d, flags_q;
  logic             vld_d, vld_q;
  logic [CH_W-1:0]  ch_d, ch_q;
  logic             hit;
  logic             ch_en;

  always_comb begin
    hit     = |new_err_i;
    ch_en   = hit;
    flags_d = (clear_i ? '0 : flags_q) | new_err_i;
    vld_d   = (clear_i ? 1'b0 : vld_q) | hit;
    ch_d    = ch_en ? ch_i : ch_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      vld_q   <= 1'b0;
      ch_q    <= '0;
    end else begin
      flags_q <= flags_d;
      vld_q   <= vld_d;
      if (ch_en) ch_q <= ch_d;
    end
  end

  assign flags_o = flags_q;
  assign vld_o   = vld_q;
  assign ch_o    = ch_q;
endmodule

// File: rtl/dma_cfg_checker.sv
module dma_cfg_checker
  import dma_cfg_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int PRIO_W = 4,
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 16,
  parameter int CNT_W  = 32,
  localparam int CH_W  = $clog2(NUM_CH)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     act_i,
  input  logic                     minor_done_i,
  input  logic                     major_done_i,
  input  logic                     clear_i,
  input  logic [CH_W-1:0]          ch_i,
  input  logic [ADDR_W-1:0]        src_addr_i,
  input  logic [ADDR_W-1:0]        dst_addr_i,
  input  logic [OFF_W-1:0]         src_off_i,
  input  logic [OFF_W-1:0]         dst_off_i,
  input  logic [2:0]               src_size_i,
  input  logic [2:0]               dst_size_i,
  input  logic [CNT_W-1:0]         nbytes_i,
  input  logic                     sg_en_i,
  input  logic [ADDR_W-1:0]        sg_addr_i,
  input  logic                     link_en_i,
  input  logic                     cur_link_i,
  input  logic                     beg_link_i,
  input  logic [NUM_CH*PRIO_W-1:0] prio_i,
  input  logic                     fixed_arb_i,
  input  logic                     err_irq_en_i,
  output logic [ERR_N-1:0]         err_flags_o,
  output logic [CH_W-1:0]          err_ch_o,
  output logic                     err_vld_o,
  output logic                     err_irq_o
);
  localparam int SIDES = 2;

  logic [SIDES-1:0][ADDR_W-1:0] side_addr;
  logic [SIDES-1:0][OFF_W-1:0]  side_off;
  logic [SIDES-1:0][2:0]        side_size;
  logic [SIDES-1:0]             side_addr_bad, side_cnt_bad, side_code_bad;

  assign side_addr = {dst_addr_i, src_addr_i};
  assign side_off  = {dst_off_i, src_off_i};
  assign side_size = {dst_size_i, src_size_i};

  genvar gs;
  generate
    for (gs = 0; gs < SIDES; gs++) begin : g_side
      dma_cfg_align #(
        .ADDR_W(ADDR_W), .OFF_W(OFF_W), .CNT_W(CNT_W)
      ) u_align (
        .addr_i    (side_addr[gs]),
        .off_i     (side_off[gs]),
        .cnt_i     (nbytes_i),
        .size_i    (side_size[gs]),
        .addr_bad_o(side_addr_bad[gs]),
        .cnt_bad_o (side_cnt_bad[gs]),
        .code_bad_o(side_code_bad[gs])
      );
    end
  endgenerate

  logic prio_dup;
  dma_cfg_prio_uniq #(.NUM_CH(NUM_CH), .PRIO_W(PRIO_W)) u_prio (
    .prio_i(prio_i),
    .dup_o (prio_dup)
  );

  logic [ERR_N-1:0] new_err;
  logic [ADDR_W-1:0] sg_mask;

  always_comb begin
    sg_mask = {{(ADDR_W-LOW_W){1'b0}}, {LOW_W{1'b1}}};
    new_err = '0;
    new_err[E_SRC_ALIGN] = act_i && side_addr_bad[0];
    new_err[E_DST_ALIGN] = act_i && side_addr_bad[1];
    new_err[E_COUNT]     = act_i && (|side_cnt_bad);
    new_err[E_SIZE_CODE] = act_i && (|side_code_bad);
    new_err[E_PRIO]      = act_i && fixed_arb_i && prio_dup;
    new_err[E_SG_ALIGN]  = major_done_i && sg_en_i && ((sg_addr_i & sg_mask) != '0);
    new_err[E_LINK]      = minor_done_i && link_en_i && (cur_link_i != beg_link_i);
  end

  dma_cfg_err_reg #(.CH_W(CH_W)) u_reg (
    .clk      (clk),
    .rst_n    (rst_n),
    .new_err_i(new_err),
    .ch_i     (ch_i),
    .clear_i  (clear_i),
    .flags_o  (err_flags_o),
    .vld_o    (err_vld_o),
    .ch_o     (err_ch_o)
  );

  assign err_irq_o = err_vld_o && err_irq_en_i;
endmodule

// File: rtl/dma_cfg_checker_sva.sv
module dma_cfg_checker_sva
  import dma_cfg_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             act_i,
  input logic             minor_done_i,
  input logic             major_done_i,
  input logic             clear_i,
  input logic             err_irq_en_i,
  input logic [ERR_N-1:0] err_flags_o,
  input logic             err_vld_o,
  input logic             err_irq_o
);
  p_act_class_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (|(err_flags_o[E_PRIO:0] & ~$past(err_flags_o[E_PRIO:0]))) |-> $past(act_i));

  p_sg_at_major_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_flags_o[E_SG_ALIGN]) |-> $past(major_done_i));

  p_link_at_minor_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_flags_o[E_LINK]) |-> $past(minor_done_i));

  p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !clear_i |=> ((err_flags_o & $past(err_flags_o)) == $past(err_flags_o)));

  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_i && !act_i && !minor_done_i && !major_done_i) |=> (err_flags_o == '0 && !err_vld_o));

  p_vld_r10: assert property (@(posedge clk) disable iff (!rst_n)
    err_vld_o |-> (|err_flags_o));

  p_irq_r11: assert property (@(posedge clk) disable iff (!rst_n)
    err_irq_o |-> (err_vld_o && err_irq_en_i));
endmodule

bind dma_cfg_checker dma_cfg_checker_sva u_sva (
  .clk         (clk),
  .rst_n       (rst_n),
  .act_i       (act_i),
  .minor_done_i(minor_done_i),
  .major_done_i(major_done_i),
  .clear_i     (clear_i),
  .err_irq_en_i(err_irq_en_i),
  .err_flags_o (err_flags_o),
  .err_vld_o   (err_vld_o),
  .err_irq_o   (err_irq_o)
);

// File: tb/dma_cfg_checker_tb.sv
module dma_cfg_checker_tb;
  localparam int NUM_CH = 8;
  localparam int PRIO_W = 4;
  localparam int CH_W   = 3;

  logic clk, rst_n;
  logic act, mnr, mjr, clr;
  logic [CH_W-1:0] ch;
  logic [31:0] sa, da, sga;
  logic [15:0] so, dof;
  logic [2:0] ss, ds;
  logic [31:0] nb;
  logic sg_en, lk_en, cur_lk, beg_lk, fixed, irq_en;
  logic [NUM_CH*PRIO_W-1:0] prio;
  logic [6:0] flags;
  logic [CH_W-1:0] ech;
  logic vld, irq;

  dma_cfg_checker u_dut (
    .clk(clk), .rst_n(rst_n), .act_i(act), .minor_done_i(mnr), .major_done_i(mjr),
    .clear_i(clr), .ch_i(ch), .src_addr_i(sa), .dst_addr_i(da), .src_off_i(so),
    .dst_off_i(dof), .src_size_i(ss), .dst_size_i(ds), .nbytes_i(nb), .sg_en_i(sg_en),
    .sg_addr_i(sga), .link_en_i(lk_en), .cur_link_i(cur_lk), .beg_link_i(beg_lk),
    .prio_i(prio), .fixed_arb_i(fixed), .err_irq_en_i(irq_en),
    .err_flags_o(flags), .err_ch_o(ech), .err_vld_o(vld), .err_irq_o(irq)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  typedef struct {
    string           tag;
    logic [6:0]      f;
    logic            v;
    logic [CH_W-1:0] c;
    logic            i;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int fails  = 0;
  logic [6:0] m_f;
  logic m_v;
  logic [CH_W-1:0] m_c;
  bit done = 0;

  function automatic bit not_mult(input longint unsigned val, input int code);
    longint unsigned sz = 64'd1 << code;
    return (val % sz) != 0;
  endfunction

  task automatic set_clean();
    sa = 32'h100; so = 16'd4; ss = 3'd2;
    da = 32'h208; dof = 16'd8; ds = 3'd3;
    nb = 32'd32; sg_en = 0; sga = 32'h1000;
    lk_en = 0; cur_lk = 0; beg_lk = 0; fixed = 1;
    for (int k = 0; k < NUM_CH; k++) prio[k*PRIO_W +: PRIO_W] = PRIO_W'(k);
  endtask

  task automatic do_event(input string tag, input bit a, input bit mn, input bit mj,
                          input bit c, input logic [CH_W-1:0] chn);
    logic [6:0] nw;
    bit dup;
    exp_t e;
    @(negedge clk);
    act = a; mnr = mn; mjr = mj; clr = c; ch = chn;
    nw = '0;
    dup = 0;
    for (int x = 0; x < NUM_CH; x++)
      for (int y = x + 1; y < NUM_CH; y++)
        if (prio[x*PRIO_W +: PRIO_W] == prio[y*PRIO_W +: PRIO_W]) dup = 1;
    if (a) begin
      if (ss <= 5 && (not_mult(sa, ss) || not_mult({48'd0, so}, ss))) nw[0] = 1;
      if (ds <= 5 && (not_mult(da, ds) || not_mult({48'd0, dof}, ds))) nw[1] = 1;
      if ((ss <= 5 && not_mult(nb, ss)) || (ds <= 5 && not_mult(nb, ds))) nw[2] = 1;
      if (ss > 5 || ds > 5) nw[3] = 1;
      if (fixed && dup) nw[4] = 1;
    end
    if (mj && sg_en && not_mult(sga, 5)) nw[5] = 1;
    if (mn && lk_en && (cur_lk != beg_lk)) nw[6] = 1;
    if (c) begin m_f = '0; m_v = 0; end
    m_f = m_f | nw;
    if (nw != 0) begin m_v = 1; m_c = chn; end
    @(posedge clk);
    #1;
    e.tag = tag; e.f = m_f; e.v = m_v; e.c = m_c; e.i = m_v && irq_en;
    q.push_back(e);
    @(negedge clk);
    act = 0; mnr = 0; mjr = 0; clr = 0;
  endtask

  // Monitor: compare outputs with the scoreboard shortly after each edge.
  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      #2;
      while (q.size() > 0) begin
        e = q.pop_front();
        checks++;
        if (flags !== e.f || vld !== e.v || irq !== e.i || (e.v && ech !== e.c)) begin
          fails++;
          $display("FAIL %s: flags=%b vld=%b ch=%0d irq=%b expected flags=%b vld=%b ch=%0d irq=%b",
                   e.tag, flags, vld, ech, irq, e.f, e.v, e.c, e.i);
        end
      end
    end
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 0; act = 0; mnr = 0; mjr = 0; clr = 0; ch = '0; irq_en = 1;
    set_clean();
    m_f = '0; m_v = 0; m_c = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    @(negedge clk);
    checks++;
    if (flags !== 7'b0 || vld !== 1'b0 || irq !== 1'b0) begin
      fails++;
      $display("FAIL reset R9: flags=%b vld=%b irq=%b expected 0 0 0", flags, vld, irq);
    end

    do_event("R1 clean activation", 1, 0, 0, 0, 3'd2);
    sa = 32'h102;
    do_event("R1 src address misaligned", 1, 0, 0, 0, 3'd3);
    do_event("R9 clear", 0, 0, 0, 1, 3'd0);
    sa = 32'h100; so = 16'd6;
    do_event("R1 src offset misaligned", 1, 0, 0, 0, 3'd1);
    set_clean(); da = 32'h204;
    do_event("R2 R9 dst misaligned, src flag sticky", 1, 0, 0, 0, 3'd5);
    set_clean(); dof = 16'hfff8;
    do_event("R2 R9 clear, negative aligned dst offset", 1, 0, 0, 1, 3'd5);
    dof = 16'hfffc;
    do_event("R2 negative misaligned dst offset", 1, 0, 0, 1, 3'd6);
    set_clean(); nb = 32'd36;
    do_event("R3 byte count not multiple of dst size", 1, 0, 0, 1, 3'd4);
    set_clean(); ss = 3'd6; ds = 3'd0; nb = 32'd5;
    do_event("R4 illegal source size code", 1, 0, 0, 1, 3'd7);
    set_clean(); prio[5*PRIO_W +: PRIO_W] = 4'd3;
    do_event("R5 duplicate priority in fixed mode", 1, 0, 0, 1, 3'd0);
    fixed = 0;
    do_event("R5 duplicate priority in round-robin mode", 1, 0, 0, 1, 3'd0);
    set_clean(); sga = 32'h1010; sg_en = 1; lk_en = 1; cur_lk = 1; beg_lk = 0;
    do_event("R8 faulty descriptor, no strobe", 0, 0, 0, 0, 3'd1);
    do_event("R6 R7 activation ignores sg and link faults", 1, 0, 0, 0, 3'd1);
    do_event("R7 link mismatch at minor completion", 0, 1, 0, 0, 3'd2);
    do_event("R6 sg misaligned at major completion", 0, 0, 1, 1, 3'd3);
    lk_en = 0;
    do_event("R7 link disabled at minor completion", 0, 1, 0, 1, 3'd4);
    sga = 32'h1020;
    do_event("R6 sg aligned at major completion", 0, 0, 1, 1, 3'd4);
    sg_en = 0; sga = 32'h1011;
    do_event("R6 sg disabled at major completion", 0, 0, 1, 1, 3'd4);
    set_clean(); irq_en = 0; sa = 32'h101;
    do_event("R11 R10 error with interrupt disabled", 1, 0, 0, 0, 3'd6);
    irq_en = 1;
    do_event("R9 clear with simultaneous error kept", 1, 0, 0, 1, 3'd2);
    set_clean();
    do_event("R11 R9 clean clear drops interrupt", 0, 0, 0, 1, 3'd0);

    repeat (3) @(posedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule